// File: doc/BRIEF.md
# Serial Arithmetic Shift Unit

This block executes the two arithmetic shift operations of a register-file processor on a single 16-bit register value. It supports a right shift that copies the sign bit into the vacated high positions and a left shift that fills zeros from the bottom. When the shift completes, the block returns the shifted value. It also returns a carry flag, an overflow flag and three compare-against-zero flags: unsigned greater, signed greater and equal. The surrounding pipeline fetches and decodes the instruction, reads the register file, and writes the result back.

The shift amount is normally taken from a 4-bit field of the instruction. If that field is zero, the low four bits of a dedicated count register supply the amount instead. If both are zero, the unit shifts by the full 16 positions. The unit moves one bit position per clock. A one-cycle completion pulse marks the cycle in which the result and flags become valid, and they stay unchanged until the next operation finishes.

Top module: `arith_shifter`

## Requirements
- R1: The shift count n is `cnt_field_i` when that field is nonzero. Otherwise n is `cnt_reg_i[3:0]` when that is nonzero. Otherwise n is 16. The upper twelve bits of `cnt_reg_i` never influence n.
- R2: With `op_i` = 0 (right arithmetic), the result is the operand shifted right by n with every vacated bit equal to the operand's bit 15. This equals the signed operand divided by 2^n, rounded toward negative infinity.
- R3: With `op_i` = 1 (left arithmetic), the result is the operand shifted left by n with zeros entering at bit 0. Bits moved past bit 15 are discarded.
- R4: `carry_o` equals the last bit shifted out. For a right shift this is operand bit n-1. For a left shift it is operand bit 16-n.
- R5: For a left shift, `ovf_o` is 1 exactly when bit 15 changes value after at least one of the n single-bit steps. For a right shift, `ovf_o` is 0.
- R6: `eq_o` is 1 when the result is zero. `lgt_o` is 1 when the result is nonzero. `agt_o` is 1 when the result is nonzero and its bit 15 is 0.
- R7: A start accepted at a rising edge makes `done_o` high for exactly one cycle, following the (n+1)-th rising edge after the accepting edge.
- R8: `result_o` and all flags change only together with `done_o`. A `start_i` raised while an operation is in progress is ignored and does not alter that operation's outcome.
- R9: While `rst_n` is low and after its release, `result_o` and all flags read 0 and `done_o` reads 0 until the first operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 1 | 0 = shift right arithmetic, 1 = shift left arithmetic |
| operand_i | input | 16 | Register value to shift |
| cnt_field_i | input | 4 | Shift count field from the instruction |
| cnt_reg_i | input | 16 | Count register value; low four bits used when the field is zero |
| result_o | output | 16 | Shifted value |
| carry_o | output | 1 | Last bit shifted out |
| ovf_o | output | 1 | Sign change during a left shift |
| lgt_o | output | 1 | Result is nonzero (unsigned greater than zero) |
| agt_o | output | 1 | Result is positive as a signed value |
| eq_o | output | 1 | Result is zero |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every result and flag becomes visible after the (n+1)-th rising edge that follows the edge accepting `start_i`. The bench counts falling edges from that acceptance until `done_o` appears and requires the count to equal n+1 for the count it derived itself. It reads the result and the five flags on that same falling edge, then confirms one falling edge later that `done_o` has dropped and the outputs are unchanged. The sweep covers every field value and, with a zero field, every count-register value, including the 16-position case. It runs both directions over several operands. A busy-time start is injected mid-operation to confirm it has no effect.

// File: rtl/ash_pkg.sv
package ash_pkg;

  typedef enum logic {
    OP_SRA = 1'b0,
    OP_SLA = 1'b1
  } shift_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } shift_state_e;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic lgt;
    logic agt;
    logic eq;
  } shift_flags_t;

endpackage

// File: rtl/ash_count_sel.sv
module ash_count_sel #(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic [CW-1:0] field_i,
  input  logic [CW-1:0] reg_low_i,
  output logic [CW:0]   count_o
);

  localparam logic [CW:0] FULL_COUNT = (CW+1)'(WIDTH);

  always_comb begin
    if (field_i != '0) begin
      count_o = {1'b0, field_i};
    end else if (reg_low_i != '0) begin
      count_o = {1'b0, reg_low_i};
    end else begin
      count_o = FULL_COUNT;
    end
  end

endmodule

// File: rtl/ash_shift_core.sv
module ash_shift_core
  import ash_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  shift_op_e        op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [CW:0]      count_i,
  output logic [WIDTH-1:0] acc_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             busy_o,
  output logic             fin_o
);

  localparam logic [CW:0] ONE = (CW+1)'(1);

  shift_state_e     st_q, st_d;
  logic [WIDTH-1:0] acc_q, acc_d;
  logic [CW:0]      rem_q, rem_d;
  shift_op_e        op_q, op_d;
  logic             cy_q, cy_d;
  logic             ov_q, ov_d;
  logic             step_en;

  assign step_en = (st_q != ST_IDLE) || start_i;

  always_comb begin
    st_d  = st_q;
    acc_d = acc_q;
    rem_d = rem_q;
    op_d  = op_q;
    cy_d  = cy_q;
    ov_d  = ov_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          acc_d = operand_i;
          rem_d = count_i;
          op_d  = op_i;
          cy_d  = 1'b0;
          ov_d  = 1'b0;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        if (op_q == OP_SLA) begin
          acc_d = {acc_q[WIDTH-2:0], 1'b0};
          cy_d  = acc_q[WIDTH-1];
          ov_d  = ov_q | (acc_q[WIDTH-1] ^ acc_q[WIDTH-2]);
        end else begin
          acc_d = {acc_q[WIDTH-1], acc_q[WIDTH-1:1]};
          cy_d  = acc_q[0];
          ov_d  = 1'b0;
        end
        rem_d = rem_q - ONE;
        if (rem_q == ONE) begin
          st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      acc_q <= '0;
      rem_q <= '0;
      op_q  <= OP_SRA;
      cy_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else if (step_en) begin
      st_q  <= st_d;
      acc_q <= acc_d;
      rem_q <= rem_d;
      op_q  <= op_d;
      cy_q  <= cy_d;
      ov_q  <= ov_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = cy_q;
  assign ovf_o   = ov_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign fin_o   = (st_q == ST_DRAIN);

endmodule

// File: rtl/ash_flag_eval.sv
module ash_flag_eval #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             lgt_o,
  output logic             agt_o,
  output logic             eq_o
);

  logic nonzero;

  assign nonzero = |value_i;
  assign lgt_o   = nonzero;
  assign agt_o   = nonzero & ~value_i[WIDTH-1];
  assign eq_o    = ~nonzero;

endmodule

// File: rtl/arith_shifter.sv
module arith_shifter
  import ash_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             op_i,
  input  logic [WIDTH-1:0] operand_i,
  input  logic [CW-1:0]    cnt_field_i,
  input  logic [WIDTH-1:0] cnt_reg_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             lgt_o,
  output logic             agt_o,
  output logic             eq_o,
  output logic             done_o
);

  logic [CW:0]      count;
  logic [WIDTH-1:0] acc;
  logic             core_cy;
  logic             core_ov;
  logic             busy;
  logic             fin;
  logic             f_lgt, f_agt, f_eq;
  logic             unused_cnt_hi;

  logic [WIDTH-1:0] res_q, res_d;
  shift_flags_t     flg_q, flg_d;
  logic             done_q, done_d;
  logic             out_en;

  assign unused_cnt_hi = ^cnt_reg_i[WIDTH-1:CW];

  ash_count_sel #(.WIDTH(WIDTH)) u_count_sel (
    .field_i   (cnt_field_i),
    .reg_low_i (cnt_reg_i[CW-1:0]),
    .count_o   (count)
  );

  ash_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (shift_op_e'(op_i)),
    .operand_i (operand_i),
    .count_i   (count),
    .acc_o     (acc),
    .carry_o   (core_cy),
    .ovf_o     (core_ov),
    .busy_o    (busy),
    .fin_o     (fin)
  );

  ash_flag_eval #(.WIDTH(WIDTH)) u_flags (
    .value_i (acc),
    .lgt_o   (f_lgt),
    .agt_o   (f_agt),
    .eq_o    (f_eq)
  );

  assign out_en = fin || done_q;

  always_comb begin
    res_d  = res_q;
    flg_d  = flg_q;
    done_d = 1'b0;
    if (fin) begin
      res_d       = acc;
      flg_d.carry = core_cy;
      flg_d.ovf   = core_ov;
      flg_d.lgt   = f_lgt;
      flg_d.agt   = f_agt;
      flg_d.eq    = f_eq;
      done_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else if (out_en) begin
      res_q  <= res_d;
      flg_q  <= flg_d;
      done_q <= done_d;
    end
  end

  assign result_o = res_q;
  assign carry_o  = flg_q.carry;
  assign ovf_o    = flg_q.ovf;
  assign lgt_o    = flg_q.lgt;
  assign agt_o    = flg_q.agt;
  assign eq_o     = flg_q.eq;
  assign done_o   = done_q;

endmodule

// File: rtl/ash_checker.sv
module ash_checker
  import ash_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int CW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             op_i,
  input logic [CW-1:0]    cnt_field_i,
  input logic [WIDTH-1:0] cnt_reg_i,
  input logic             busy,
  input logic [WIDTH-1:0] result_o,
  input logic             ovf_o,
  input logic             lgt_o,
  input logic             agt_o,
  input logic             eq_o,
  input logic             done_o
);

  logic [CW:0] want_n;
  logic [7:0]  lat_cnt;
  logic [7:0]  lat_exp;
  logic        op_seen;
  logic        unused_chk_hi;

  assign unused_chk_hi = ^cnt_reg_i[WIDTH-1:CW];

  always_comb begin
    if (cnt_field_i != '0)               want_n = {1'b0, cnt_field_i};
    else if (cnt_reg_i[CW-1:0] != '0)    want_n = {1'b0, cnt_reg_i[CW-1:0]};
    else                                 want_n = (CW+1)'(WIDTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_exp <= '0;
      op_seen <= 1'b0;
    end else if (start_i && !busy) begin
      lat_cnt <= '0;
      lat_exp <= 8'(want_n) + 8'd1;
      op_seen <= op_i;
    end else if (lat_cnt != 8'hFF) begin
      lat_cnt <= lat_cnt + 8'd1;
    end
  end

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                             // R7

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == lat_exp));                                // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (op_seen == OP_SRA)) |-> !ovf_o);                      // R5

  AST_EQ_MATCHES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (eq_o == (result_o == '0)));                          // R6

  AST_EQ_LGT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (eq_o != lgt_o));                                     // R6

  AST_AGT_SIGNED_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    agt_o |-> (lgt_o && !result_o[WIDTH-1]));                        // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));                                  // R8

endmodule

bind arith_shifter ash_checker #(.WIDTH(WIDTH)) u_ash_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .op_i        (op_i),
  .cnt_field_i (cnt_field_i),
  .cnt_reg_i   (cnt_reg_i),
  .busy        (busy),
  .result_o    (result_o),
  .ovf_o       (ovf_o),
  .lgt_o       (lgt_o),
  .agt_o       (agt_o),
  .eq_o        (eq_o),
  .done_o      (done_o)
);

// File: tb/arith_shifter_tb_top.sv
`timescale 1ns/1ps
module arith_shifter_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        op;
  logic [15:0] opnd;
  logic [3:0]  fld;
  logic [15:0] creg;
  logic [15:0] result_o;
  logic        carry_o, ovf_o, lgt_o, agt_o, eq_o, done_o;

  int checks;
  int fails;
  bit finished;

  arith_shifter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (op),
    .operand_i   (opnd),
    .cnt_field_i (fld),
    .cnt_reg_i   (creg),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .ovf_o       (ovf_o),
    .lgt_o       (lgt_o),
    .agt_o       (agt_o),
    .eq_o        (eq_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic o, input logic [15:0] x,
                        input logic [3:0] f, input logic [15:0] r);
    int n;
    int k;
    int v;
    int d;
    int q;
    logic [15:0] e_res;
    logic        e_cy;
    logic        e_ov;
    logic [31:0] shl;
    logic [31:0] ext;
    if (f != 4'd0)            n = int'(f);
    else if (r[3:0] != 4'd0)  n = int'(r[3:0]);
    else                      n = 16;
    @(negedge clk);
    start = 1'b1; op = o; opnd = x; fld = f; creg = r;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done_o && k < 40) begin
      @(negedge clk);
      k++;
    end
    chk(k == n + 1, "R1/R7 latency", 32'(k), 32'(n + 1));
    if (o == 1'b0) begin
      v = int'($signed(x));
      d = 1 << n;
      if (v >= 0) q = v / d;
      else        q = -((-v + d - 1) / d);
      e_res = q[15:0];
      e_cy  = x[n-1];
      e_ov  = 1'b0;
      chk(result_o == e_res, "R2 right result", 32'(result_o), 32'(e_res));
    end else begin
      shl   = {16'h0, x} << n;
      e_res = shl[15:0];
      e_cy  = x[16-n];
      ext   = {x, 16'h0};
      e_ov  = 1'b0;
      for (int s = 1; s <= n; s++) begin
        if (ext[31-s] != ext[32-s]) e_ov = 1'b1;
      end
      chk(result_o == e_res, "R3 left result", 32'(result_o), 32'(e_res));
    end
    chk(carry_o == e_cy, "R4 carry", 32'(carry_o), 32'(e_cy));
    chk(ovf_o == e_ov, "R5 overflow", 32'(ovf_o), 32'(e_ov));
    chk({lgt_o, agt_o, eq_o} == {e_res != 0, (e_res != 0) && !e_res[15], e_res == 0},
        "R6 compare flags", 32'({lgt_o, agt_o, eq_o}),
        32'({e_res != 0, (e_res != 0) && !e_res[15], e_res == 0}));
    @(negedge clk);
    chk(done_o == 1'b0, "R7 single pulse", 32'(done_o), 32'h0);
    chk(result_o == e_res, "R8 result held", 32'(result_o), 32'(e_res));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [8];
    checks = 0;
    fails = 0;
    finished = 1'b0;
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8000; pats[3] = 16'h7FFF;
    pats[4] = 16'hBAAA; pats[5] = 16'h5555; pats[6] = 16'h0001; pats[7] = 16'hC000;
    rst_n = 1'b0; start = 1'b0; op = 1'b0; opnd = '0; fld = '0; creg = '0;
    repeat (3) @(negedge clk);
    chk({result_o, carry_o, ovf_o, lgt_o, agt_o, eq_o, done_o} == '0,
        "R9 in reset", 32'({result_o, carry_o, ovf_o, lgt_o, agt_o, eq_o, done_o}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({result_o, carry_o, ovf_o, lgt_o, agt_o, eq_o, done_o} == '0,
        "R9 after release", 32'({result_o, carry_o, ovf_o, lgt_o, agt_o, eq_o, done_o}), 32'h0);

    for (int o = 0; o < 2; o++) begin
      for (int p = 0; p < 8; p++) begin
        for (int f = 1; f < 16; f++) begin
          run_op(o[0], pats[p], 4'(f), 16'hFFF0 | 16'(p));
        end
        for (int r = 0; r < 16; r++) begin
          run_op(o[0], pats[p], 4'd0, 16'h5A50 | 16'(r));
        end
      end
    end

    // R8: a start during a running operation must be ignored
    @(negedge clk);
    start = 1'b1; op = 1'b0; opnd = 16'h8000; fld = 4'd0; creg = 16'h1230;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 1'b1; opnd = 16'h0001; fld = 4'd1; creg = 16'h0003;
    @(negedge clk);
    start = 1'b0;
    begin
      int k;
      k = 6;
      while (!done_o && k < 40) begin
        @(negedge clk);
        k++;
      end
      chk(k == 17, "R8 busy start latency", 32'(k), 32'd17);
      chk(result_o == 16'hFFFF, "R8 busy start ignored", 32'(result_o), 32'hFFFF);
      chk(carry_o == 1'b1, "R8 busy start carry", 32'(carry_o), 32'h1);
    end
    repeat (5) @(negedge clk);
    chk(result_o == 16'hFFFF && !done_o, "R8 idle hold", 32'({done_o, result_o}), 32'h0FFFF);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule